// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write-Unlock

This peripheral watches for a stalled system with two count-down stages in a chain. While it is enabled, stage one counts down from its preload. When stage one runs out, the block latches an interrupt status bit and loads stage two from its own preload. When stage two also runs out, the block sets a sticky timed-out flag and can drive a reset request for a fixed number of clock cycles. Software keeps the system alive by restarting stage one before either stage expires.

The two preloads and the reload/flag register are protected. A write to any of them takes effect only after the key 0x80 and then the key 0x86 have been written to the reload register, and each unlock admits exactly one protected write. A control register holds the enable bit and a lock bit. Once the lock bit is set, only a power-on reset clears it, and while it is set the enable bit cannot be cleared. A configuration register selects the tick rate, the interrupt type and whether the reset request is driven.

Registers are accessed over a plain synchronous bus. A write is taken on the clock edge where `bus_wr_en` is high. A read is combinational from `bus_addr`. The synchronous `soft_rst` input stands for the system reset. It leaves the lock bit and the timed-out flag alone, and it also leaves the enable bit alone while the lock is set.

Top module: `wdt2_top`

## Requirements
- R1: After power-on reset both preloads read 0x03C00, and the status, reload/flag, configuration and control registers read 0. `irq` and `rst_req` are low.
- R2: A write to a protected register (offsets 0x00 stage-1 preload, 0x04 stage-2 preload, 0x0C reload/flag) is ignored unless it is preceded by writes of exactly 0x80 and then exactly 0x86 to offset 0x0C.
- R3: After an unlock, exactly one protected write is accepted and the block relocks. Any other value written to 0x0C while the unlock is pending returns it to idle.
- R4: A protected write to 0x0C with bit 8 set restarts stage one from the stage-1 preload. This also applies while stage two is running.
- R5: With tick period T, stage one expires P1·T cycles after a restart and sets status bit 0 at offset 0x08. Stage two expires a further P2·T cycles later.
- R6: Configuration bit 2 (offset 0x10) selects the tick period: 0 gives 2^SLOW_LOG2 clocks and 1 gives 2^FAST_LOG2 clocks.
- R7: `irq` equals status bit 0 unless configuration bits 1:0 are 11, which masks it. Writing 1 to status bit 0 clears it.
- R8: On stage-two expiry `rst_req` is high for exactly 16 cycles if configuration bit 5 is 0. It stays low if bit 5 is 1.
- R9: Stage-two expiry sets the timed-out flag, which reads as bit 9 of 0x0C. A protected write with bit 9 set clears it, and `soft_rst` does not clear it.
- R10: Control register 0x14 has bit 0 = lock (set-only) and bit 1 = enable. While the lock is set, the enable cannot be cleared by a write or by `soft_rst`. Without the lock, writing 0 clears the enable.
- R11: The counter runs only while enable is 1 and control bit 2 (function select) is 0. Turning the counter on loads stage one one cycle after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous system reset; keeps the lock bit and the timed-out flag |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Stage-one expiry interrupt, level |
| rst_req | output | 1 | Stage-two expiry reset request pulse |

## Verification
A corrupted unlock state shows up within one bus write: a preload read-back either keeps a value that should have changed or takes one that should have been refused. A counter or stage fault moves the first cycle of `irq` or `rst_req` away from its arithmetic position P1·T or (P1+P2)·T. The sweep over preloads and both tick rates catches this to the exact cycle. Faults in the lock, the flag and the masking appear in the control, flag and status read-back, and in whether `irq` and `rst_req` stay low when masked.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  typedef enum logic [1:0] {UL_IDLE, UL_ARMED, UL_OPEN} unlock_e;
  typedef enum logic [1:0] {CS_OFF, CS_FIRST, CS_SECOND, CS_DONE} cstage_e;

  localparam logic [4:0] OFS_PRE1 = 5'h00;
  localparam logic [4:0] OFS_PRE2 = 5'h04;
  localparam logic [4:0] OFS_STAT = 5'h08;
  localparam logic [4:0] OFS_RLD  = 5'h0C;
  localparam logic [4:0] OFS_CFG  = 5'h10;
  localparam logic [4:0] OFS_CTL  = 5'h14;

  localparam int KEY_FIRST  = 'h80;
  localparam int KEY_SECOND = 'h86;
endpackage

// File: rtl/wdt2_unlock.sv
module wdt2_unlock
  import wdt2_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic soft_rst,
  input  logic rld_wr,
  input  logic prot_wr,
  input  logic key1_hit,
  input  logic key2_hit,
  output logic open
);
  unlock_e st_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) st_q <= UL_IDLE;
    else if (soft_rst) st_q <= UL_IDLE;
    else begin
      case (st_q)
        UL_IDLE:  if (rld_wr) st_q <= key1_hit ? UL_ARMED : UL_IDLE;
        UL_ARMED: if (rld_wr) st_q <= key2_hit ? UL_OPEN : UL_IDLE;
        UL_OPEN:  if (prot_wr) st_q <= UL_IDLE;
        default:  st_q <= UL_IDLE;
      endcase
    end
  end

  assign open = (st_q == UL_OPEN);

  AST_OPEN_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == UL_OPEN) |-> ($past(st_q) == UL_ARMED || $past(st_q) == UL_OPEN)); // R2
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == UL_OPEN && prot_wr) |=> (st_q == UL_IDLE)); // R3
endmodule

// File: rtl/wdt2_prescaler.sv
module wdt2_prescaler #(
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic clk,
  input  logic por_n,
  input  logic clear,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int W = SLOW_LOG2;
  localparam logic [W-1:0] LIM_SLOW = '1;
  localparam logic [W-1:0] LIM_FAST = W'((1 << FAST_LOG2) - 1);

  logic [W-1:0] pcnt_q;
  logic [W-1:0] limit;

  assign limit = fast ? LIM_FAST : LIM_SLOW;
  assign tick  = run && !clear && (pcnt_q >= limit);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) pcnt_q <= '0;
    else if (clear || !run || tick) pcnt_q <= '0;
    else pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt2_countdown.sv
module wdt2_countdown
  import wdt2_pkg::*;
#(
  parameter int PRE_W     = 20,
  parameter int PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             soft_rst,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [PRE_W-1:0] pre1,
  input  logic [PRE_W-1:0] pre2,
  input  logic             rst_en,
  output logic             s1_exp,
  output logic             s2_exp,
  output logic             prs_clear,
  output logic             counting,
  output logic             rst_req
);
  localparam int PLS_W = $clog2(PULSE_LEN + 1);

  cstage_e          st_q;
  logic [PRE_W-1:0] cnt_q;
  logic [PLS_W-1:0] pls_q;
  logic             load, last;

  assign load      = run && (restart || st_q == CS_OFF);
  assign last      = (cnt_q <= PRE_W'(1));
  assign s1_exp    = run && !soft_rst && !load && tick && st_q == CS_FIRST && last;
  assign s2_exp    = run && !soft_rst && !load && tick && st_q == CS_SECOND && last;
  assign prs_clear = load || !run;
  assign counting  = (st_q == CS_FIRST) || (st_q == CS_SECOND);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q  <= CS_OFF;
      cnt_q <= '0;
    end else if (soft_rst || !run) begin
      st_q  <= CS_OFF;
      cnt_q <= '0;
    end else if (load) begin
      st_q  <= CS_FIRST;
      cnt_q <= pre1;
    end else if (tick) begin
      case (st_q)
        CS_FIRST: begin
          if (last) begin
            st_q  <= CS_SECOND;
            cnt_q <= pre2;
          end else cnt_q <= cnt_q - 1'b1;
        end
        CS_SECOND: begin
          if (last) st_q <= CS_DONE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) pls_q <= '0;
    else if (s2_exp && rst_en) pls_q <= PLS_W'(PULSE_LEN);
    else if (pls_q != '0) pls_q <= pls_q - 1'b1;
  end

  assign rst_req = (pls_q != '0);

  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == CS_SECOND && $past(st_q) != CS_SECOND) |-> ($past(st_q) == CS_FIRST)); // R5
  AST_RST_NOT_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_req) |=> rst_req); // R8
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
  import wdt2_pkg::*;
#(
  parameter int              PRE_W     = 20,
  parameter int              DATA_W    = PRE_W,
  parameter int              SLOW_LOG2 = 15,
  parameter int              FAST_LOG2 = 5,
  parameter int              PULSE_LEN = 16,
  parameter logic [PRE_W-1:0] PRE_RESET = 20'h03C00
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst,
  input  logic              bus_wr_en,
  input  logic [4:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  logic [PRE_W-1:0] pre1_q, pre2_q;
  logic stat_q, tflag_q, lock_q, en_q, func_q;
  logic cfg_nrst_q, cfg_fast_q;
  logic [1:0] cfg_itype_q;

  logic rld_wr, prot_wr, acc, open;
  logic restart, run, tick, s1_exp, s2_exp, prs_clear, counting;
  logic key1_hit, key2_hit;

  assign rld_wr   = bus_wr_en && bus_addr == OFS_RLD;
  assign prot_wr  = bus_wr_en && (bus_addr == OFS_PRE1 || bus_addr == OFS_PRE2 || bus_addr == OFS_RLD);
  assign key1_hit = (bus_wdata == DATA_W'(KEY_FIRST));
  assign key2_hit = (bus_wdata == DATA_W'(KEY_SECOND));
  assign acc      = open && prot_wr;
  assign restart  = acc && bus_addr == OFS_RLD && bus_wdata[8];
  assign run      = en_q && !func_q;

  wdt2_unlock u_unlock (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .rld_wr(rld_wr),
    .prot_wr(prot_wr), .key1_hit(key1_hit), .key2_hit(key2_hit), .open(open)
  );

  wdt2_prescaler #(.SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2)) u_prs (
    .clk(clk), .por_n(por_n), .clear(prs_clear), .run(counting),
    .fast(cfg_fast_q), .tick(tick)
  );

  wdt2_countdown #(.PRE_W(PRE_W), .PULSE_LEN(PULSE_LEN)) u_cnt (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .run(run), .restart(restart),
    .tick(tick), .pre1(pre1_q), .pre2(pre2_q), .rst_en(!cfg_nrst_q),
    .s1_exp(s1_exp), .s2_exp(s2_exp), .prs_clear(prs_clear),
    .counting(counting), .rst_req(rst_req)
  );

  // Registers cleared by either reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pre1_q <= PRE_RESET;
      pre2_q <= PRE_RESET;
      stat_q <= 1'b0;
      cfg_nrst_q <= 1'b0;
      cfg_fast_q <= 1'b0;
      cfg_itype_q <= 2'b00;
    end else if (soft_rst) begin
      pre1_q <= PRE_RESET;
      pre2_q <= PRE_RESET;
      stat_q <= 1'b0;
      cfg_nrst_q <= 1'b0;
      cfg_fast_q <= 1'b0;
      cfg_itype_q <= 2'b00;
    end else begin
      if (acc && bus_addr == OFS_PRE1) pre1_q <= bus_wdata[PRE_W-1:0];
      if (acc && bus_addr == OFS_PRE2) pre2_q <= bus_wdata[PRE_W-1:0];
      if (s1_exp) stat_q <= 1'b1;
      else if (bus_wr_en && bus_addr == OFS_STAT && bus_wdata[0]) stat_q <= 1'b0;
      if (bus_wr_en && bus_addr == OFS_CFG) begin
        cfg_nrst_q  <= bus_wdata[5];
        cfg_fast_q  <= bus_wdata[2];
        cfg_itype_q <= bus_wdata[1:0];
      end
    end
  end

  // Registers that survive the system reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      tflag_q <= 1'b0;
      lock_q  <= 1'b0;
      en_q    <= 1'b0;
      func_q  <= 1'b0;
    end else begin
      if (s2_exp) tflag_q <= 1'b1;
      else if (acc && bus_addr == OFS_RLD && bus_wdata[9]) tflag_q <= 1'b0;
      if (soft_rst) begin
        en_q   <= lock_q && en_q;
        func_q <= lock_q && func_q;
      end else if (bus_wr_en && bus_addr == OFS_CTL) begin
        lock_q <= lock_q || bus_wdata[0];
        en_q   <= bus_wdata[1] || (lock_q && en_q);
        if (!lock_q) func_q <= bus_wdata[2];
      end
    end
  end

  assign irq = stat_q && (cfg_itype_q != 2'b11);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_PRE1: bus_rdata = DATA_W'(pre1_q);
      OFS_PRE2: bus_rdata = DATA_W'(pre2_q);
      OFS_STAT: bus_rdata[0] = stat_q;
      OFS_RLD:  bus_rdata[9] = tflag_q;
      OFS_CFG:  begin
        bus_rdata[5]   = cfg_nrst_q;
        bus_rdata[2]   = cfg_fast_q;
        bus_rdata[1:0] = cfg_itype_q;
      end
      OFS_CTL:  bus_rdata[2:0] = {func_q, en_q, lock_q};
      default:  bus_rdata = '0;
    endcase
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    $past(lock_q) |-> lock_q); // R10
  AST_LOCKED_EN_HELD: assert property (@(posedge clk) disable iff (!por_n)
    (lock_q && $past(lock_q) && $past(en_q)) |-> en_q); // R10
  AST_FLAG_KEEPS_ON_SOFT: assert property (@(posedge clk) disable iff (!por_n)
    ($past(soft_rst) && $past(tflag_q)) |-> tflag_q); // R9
endmodule

// File: tb/wdt2_top_tb.sv
module wdt2_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 4;
  localparam int FAST = 2;
  localparam int TS = 1 << SLOW;
  localparam int TF = 1 << FAST;
  localparam int DW = 20;

  logic clk = 0, por_n = 0, soft_rst = 0, bus_wr_en = 0;
  logic [4:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0, bus_rdata;
  logic irq, rst_req;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt2_top #(.SLOW_LOG2(SLOW), .FAST_LOG2(FAST)) u_dut (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .bus_wr_en(bus_wr_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input int d);
    @(negedge clk);
    bus_wr_en = 1; bus_addr = a; bus_wdata = DW'(d);
    @(negedge clk);
    bus_wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output int d);
    bus_addr = a;
    #1 d = int'(bus_rdata);
  endtask

  task automatic unlock();
    wr(5'h0C, 'h80);
    wr(5'h0C, 'h86);
  endtask

  task automatic prot(input logic [4:0] a, input int d);
    unlock();
    wr(a, d);
  endtask

  // Program preloads, restart, and measure cycles to irq / rst_req
  task automatic run_case(input int p1, input int p2, input int cfg,
                          output int t_irq, output int t_rst, output int len);
    int k;
    wr(5'h10, cfg);
    prot(5'h00, p1);
    prot(5'h04, p2);
    wr(5'h08, 1);
    prot(5'h0C, 'h100);
    t_irq = -1; t_rst = -1; len = 0; k = 0;
    while (k < 3000 && t_rst < 0) begin
      if (irq && t_irq < 0) t_irq = k;
      if (rst_req) t_rst = k;
      else begin @(negedge clk); k++; end
    end
    while (rst_req && len < 100) begin len++; @(negedge clk); end
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int v, ti, tr, ln, k;
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(5'h00, v); chk("R1 pre1", v, 'h3C00);
    rd(5'h04, v); chk("R1 pre2", v, 'h3C00);
    rd(5'h08, v); chk("R1 stat", v, 0);
    rd(5'h0C, v); chk("R1 rld", v, 0);
    rd(5'h10, v); chk("R1 cfg", v, 0);
    rd(5'h14, v); chk("R1 ctl", v, 0);
    chk("R1 irq", irq, 0); chk("R1 rst_req", rst_req, 0);

    // R2 / R3 unlock rules
    wr(5'h00, 'h11); rd(5'h00, v); chk("R2 no unlock", v, 'h3C00);
    unlock(); wr(5'h00, 5); wr(5'h00, 7); rd(5'h00, v); chk("R3 one write", v, 5);
    wr(5'h0C, 'h80); wr(5'h0C, 'h85); wr(5'h0C, 'h86); wr(5'h00, 9);
    rd(5'h00, v); chk("R3 bad key", v, 5);
    wr(5'h0C, 'h86); wr(5'h00, 9); rd(5'h00, v); chk("R2 key order", v, 5);

    // R11 function select blocks counting
    prot(5'h00, 1); prot(5'h04, 1);
    wr(5'h10, 'h4);
    wr(5'h14, 'h6);
    repeat (40) @(negedge clk);
    chk("R11 func holds irq", irq, 0);
    rd(5'h0C, v); chk("R11 func holds flag", v, 0);
    wr(5'h14, 'h2);
    k = 0; ti = -1;
    while (k < 100 && ti < 0) begin if (irq) ti = k; else begin @(negedge clk); k++; end end
    chk("R11 start delay", ti, 1 + TF);
    while (!rst_req && k < 200) begin @(negedge clk); k++; end
    repeat (20) @(negedge clk);
    prot(5'h0C, 'h200);

    // R5 / R6 / R8 / R9 sweep of preloads at the fast rate
    for (int a = 1; a <= 3; a++) begin
      for (int b = 1; b <= 3; b++) begin
        run_case(a, b, 'h4, ti, tr, ln);
        chk($sformatf("R5 irq p1=%0d p2=%0d", a, b), ti, a * TF);
        chk($sformatf("R5 rst p1=%0d p2=%0d", a, b), tr, (a + b) * TF);
        chk("R8 pulse len", ln, 16);
        rd(5'h0C, v); chk("R9 flag set", v, 'h200);
        wr(5'h0C, 'h200); rd(5'h0C, v); chk("R9 unprotected clear ignored", v, 'h200);
        prot(5'h0C, 'h200); rd(5'h0C, v); chk("R9 flag clear", v, 0);
      end
    end

    // R6 slow rate
    run_case(2, 1, 'h0, ti, tr, ln);
    chk("R6 slow irq", ti, 2 * TS);
    chk("R6 slow rst", tr, 3 * TS);
    prot(5'h0C, 'h200);

    // R4 restart during stage two
    wr(5'h10, 'h4); prot(5'h00, 2); prot(5'h04, 3);
    wr(5'h08, 1); prot(5'h0C, 'h100);
    k = 0; while (!irq && k < 100) begin @(negedge clk); k++; end
    chk("R4 irq first", k, 2 * TF);
    wr(5'h08, 1); prot(5'h0C, 'h100);
    k = 0; ti = -1; tr = -1;
    while (k < 200 && tr < 0) begin
      if (irq && ti < 0) ti = k;
      if (rst_req) tr = k; else begin @(negedge clk); k++; end
    end
    chk("R4 irq after restart", ti, 2 * TF);
    chk("R4 rst after restart", tr, 5 * TF);
    repeat (20) @(negedge clk);
    prot(5'h0C, 'h200);

    // R7 interrupt masking and W1C
    run_case(1, 1, 'h7, ti, tr, ln);
    chk("R7 masked irq", ti, -1);
    rd(5'h08, v); chk("R7 status set", v, 1);
    wr(5'h08, 0); rd(5'h08, v); chk("R7 write 0 keeps", v, 1);
    wr(5'h08, 1); rd(5'h08, v); chk("R7 clear", v, 0);

    // R8 reset output disabled, flag still set
    prot(5'h0C, 'h200);
    wr(5'h10, 'h24); wr(5'h08, 1); prot(5'h0C, 'h100);
    ln = 0;
    for (int i = 0; i < 40; i++) begin if (rst_req) ln++; @(negedge clk); end
    chk("R8 no rst when bit5", ln, 0);
    rd(5'h0C, v); chk("R9 flag without rst", v, 'h200);

    // R10 lock and enable
    wr(5'h14, 0); rd(5'h14, v); chk("R10 unlocked disable", v, 0);
    wr(5'h14, 3); wr(5'h14, 0); rd(5'h14, v); chk("R10 locked enable", v, 3);
    @(negedge clk); soft_rst = 1; @(negedge clk); soft_rst = 0;
    rd(5'h14, v); chk("R10 lock after soft reset", v, 3);
    rd(5'h0C, v); chk("R9 flag after soft reset", v, 'h200);
    rd(5'h00, v); chk("R1 pre1 after soft reset", v, 'h3C00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule